// File: doc/BRIEF.md
# Data Memory Unit with Pointer-Based Indirect Access

This block holds the byte-wide data space of a small 8-bit controller core. A 7-bit address picks one of four kinds of location: two indirect ports, two memory pointer registers, special-function registers that live in peripheral logic outside the block, and 64 bytes of general-purpose RAM in the upper half of the space. Everything else in the lower half is reserved. The core's datapath reads a byte, computes on it elsewhere and writes the result back. It can also set or clear a single bit in one cycle, without a separate read.

An access to one of the two indirect ports is redirected to the location named by the low seven bits of the matching pointer register. A pointer may name the other pointer, a peripheral register or RAM. If it names an indirect port, the read returns zero and the write is dropped. Peripheral registers are reached through a side port that carries the resolved address, a write strobe, write data, a read strobe and combinational read data. A mask parameter marks some of these registers as read-only, and the block never issues a write strobe to them.

Top module: `datamem_core`

## Requirements
- R1: After reset both pointer registers (01H, 03H) and all 64 RAM bytes (40H to 7FH) read as 00H.
- R2: A write to an address from 40H to 7FH is stored and read back at the same address on any later cycle. A read in the same cycle as a write returns the byte held before that write.
- R3: Addresses from 04H to 3FH that are not peripheral registers (for example 0CH, 26H, 3FH) read as 00H. Writes and bit operations to them change no stored byte and raise no peripheral write strobe.
- R4: Address 00H accesses the location whose address is bits [6:0] of the pointer at 01H.
- R5: Address 02H accesses the location whose address is bits [6:0] of the pointer at 03H.
- R6: When the selected pointer's bits [6:0] equal 00H or 02H, an indirect read returns 00H and an indirect write or bit operation changes nothing.
- R7: Peripheral registers sit at 04H to 0BH, 12H, 14H, 1EH and 20H to 25H. A write to one of them raises the peripheral write strobe for one cycle, with the resolved address and the new byte. A read of one of them raises the peripheral read strobe and returns the peripheral's read data.
- R8: The registers at 08H and 0AH are read-only by default. A write or bit operation aimed at them raises no peripheral write strobe.
- R9: A bit set (or clear) on bit index n, 0 to 7, stores the addressed byte with bit n forced to 1 (or 0) and the other bits unchanged, in the same cycle. This works for RAM, pointers and writable peripheral registers, whether the address is direct or indirect.
- R10: When strobes coincide, a byte write takes precedence over a bit operation, and a bit set takes precedence over a bit clear.
- R11: Read data is 00H in any cycle where the read strobe is low.
- R12: Both pointer registers store and read back all 8 bits. Only bits [6:0] are used as an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 7 | Direct address of the access |
| wdata | input | 8 | Byte to be written |
| rd_en | input | 1 | Read strobe; enables read data |
| wr_en | input | 1 | Byte write strobe |
| bset_en | input | 1 | Single-bit set strobe |
| bclr_en | input | 1 | Single-bit clear strobe |
| bit_idx | input | 3 | Bit index for set or clear |
| rdata | output | 8 | Read data, combinational |
| per_addr | output | 7 | Resolved address presented to peripheral registers |
| per_re | output | 1 | Peripheral read strobe |
| per_we | output | 1 | Peripheral write strobe |
| per_wdata | output | 8 | Byte to be written into the peripheral register |
| per_rdata | input | 8 | Combinational read data from peripheral registers |

## Verification
Two kinds of overlap can occur in one cycle. The first is a byte write together with a bit operation, or a set together with a clear. The second is a read together with an update of the same byte. The bench drives the strobes together on RAM, pointer and peripheral targets, both directly and through pointers. A reference model resolves each case by the precedence in R10 and by the rule that a read returns the value held before the update. The model is compared on every cycle against the read data and against the peripheral strobes, address and data. The case where one pointer is written through the other indirect port is also provoked, and the change is judged by reading the target pointer back in the next cycle.

// File: rtl/dmem_pkg.sv
// Package: shared constants and types for the data memory unit.
// Assumes a 7-bit address space whose upper half is general-purpose RAM.
package dmem_pkg;
    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int GPR_BASE  = 64;
    localparam int LOW_W     = $clog2(GPR_BASE);
    localparam int NUM_PTR   = 2;

    localparam logic [ADDR_W-1:0] IND0_ADDR = 7'h00;
    localparam logic [ADDR_W-1:0] PTR0_ADDR = 7'h01;
    localparam logic [ADDR_W-1:0] IND1_ADDR = 7'h02;
    localparam logic [ADDR_W-1:0] PTR1_ADDR = 7'h03;

    // Default peripheral register map over the lower half, one bit per address
    localparam logic [GPR_BASE-1:0] DEF_SFR_MAP = 64'h0000_003F_4014_0FF0;
    // Default read-only peripheral registers (08H, 0AH)
    localparam logic [GPR_BASE-1:0] DEF_RO_MAP  = 64'h0000_0000_0000_0500;

    typedef enum logic [2:0] {
        RGN_RSVD,
        RGN_IND,
        RGN_PTR,
        RGN_SFR,
        RGN_GPR
    } region_e;
endpackage

// File: rtl/dmem_decode.sv
// Module: address resolver. Redirects the two indirect ports through the
// pointer registers, then classifies the resolved address and tells whether
// it may be written.
// Assumes GPR_BASE is a power of two, so that the RAM index is the low address bits.
module dmem_decode
    import dmem_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int BASE = GPR_BASE,
    parameter logic [BASE-1:0] SFR_MAP = DEF_SFR_MAP,
    parameter logic [BASE-1:0] RO_MAP  = DEF_RO_MAP
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] mp0,
    input  logic [DW-1:0] mp1,
    output logic [AW-1:0] eff_addr,
    output region_e       region,
    output logic          writable
);
    localparam int LW = $clog2(BASE);

    logic [LW-1:0] low_idx;

    // Pick the target address: pointer contents for an indirect port, else the direct address
    always_comb begin
        if (addr == IND0_ADDR)      eff_addr = mp0[AW-1:0];
        else if (addr == IND1_ADDR) eff_addr = mp1[AW-1:0];
        else                        eff_addr = addr;
    end

    assign low_idx = eff_addr[LW-1:0];

    // Classify the resolved address
    always_comb begin
        if (eff_addr == IND0_ADDR || eff_addr == IND1_ADDR)      region = RGN_IND;
        else if (eff_addr == PTR0_ADDR || eff_addr == PTR1_ADDR) region = RGN_PTR;
        else if (int'(eff_addr) >= BASE)                          region = RGN_GPR;
        else if (SFR_MAP[low_idx])                                region = RGN_SFR;
        else                                                      region = RGN_RSVD;
    end

    // Writable targets: RAM, pointers and peripheral registers not marked read-only
    always_comb begin
        unique case (region)
            RGN_GPR, RGN_PTR: writable = 1'b1;
            RGN_SFR:          writable = !RO_MAP[low_idx];
            default:          writable = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmem_ptr_regs.sv
// Module: the memory pointer registers. A write loads the selected pointer
// with a full byte. Assumes at most one pointer is written per cycle.
module dmem_ptr_regs
    import dmem_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NP = NUM_PTR
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [$clog2(NP)-1:0]  sel,
    input  logic [DW-1:0]          wdata,
    output logic [NP-1:0][DW-1:0]  ptr_q
);
    for (genvar g = 0; g < NP; g++) begin : g_ptr
        // Load pointer g when selected, clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q[g] <= '0;
            else if (we && sel == g)
                ptr_q[g] <= wdata;
        end
    end
endmodule

// File: rtl/dmem_gpr.sv
// Module: general-purpose RAM built from flops, with asynchronous read and
// synchronous write. It is cleared on reset. Assumes a single access index
// shared by the read and the write.
module dmem_gpr
    import dmem_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = GPR_BASE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata
);
    logic [DEPTH-1:0][DW-1:0] cells;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        // Store one byte when its index is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[g] <= '0;
            else if (we && idx == g)
                cells[g] <= wdata;
        end
    end

    // Present the indexed byte
    assign rdata = cells[idx];
endmodule

// File: rtl/datamem_core.sv
// Module: top of the data memory unit. It resolves the address, forms the next
// byte for a write or a single-bit update, and routes the result to the RAM,
// the pointers or the peripheral side port.
// Assumes per_rdata is a combinational function of per_addr only.
module datamem_core
    import dmem_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int BASE = GPR_BASE,
    parameter logic [BASE-1:0] SFR_MAP = DEF_SFR_MAP,
    parameter logic [BASE-1:0] RO_MAP  = DEF_RO_MAP
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    input  logic                     rd_en,
    input  logic                     wr_en,
    input  logic                     bset_en,
    input  logic                     bclr_en,
    input  logic [$clog2(DW)-1:0]    bit_idx,
    output logic [DW-1:0]            rdata,
    output logic [AW-1:0]            per_addr,
    output logic                     per_re,
    output logic                     per_we,
    output logic [DW-1:0]            per_wdata,
    input  logic [DW-1:0]            per_rdata
);
    localparam int GW = $clog2(BASE);

    logic [AW-1:0]              eff_addr;
    region_e                    region;
    logic                       writable;
    logic [NUM_PTR-1:0][DW-1:0] ptr_q;
    logic [DW-1:0]              mp0, mp1;
    logic [DW-1:0]              ram_rd;
    logic [DW-1:0]              cur_byte;
    logic [DW-1:0]              bit_mask;
    logic [DW-1:0]              next_byte;
    logic                       bit_op;
    logic                       commit;
    logic                       ptr_we;
    logic                       ram_we;
    logic [$clog2(NUM_PTR)-1:0] ptr_sel;

    assign mp0 = ptr_q[0];
    assign mp1 = ptr_q[1];

    dmem_decode #(
        .AW(AW), .DW(DW), .BASE(BASE), .SFR_MAP(SFR_MAP), .RO_MAP(RO_MAP)
    ) u_dec (
        .addr     (addr),
        .mp0      (mp0),
        .mp1      (mp1),
        .eff_addr (eff_addr),
        .region   (region),
        .writable (writable)
    );

    dmem_ptr_regs #(.DW(DW), .NP(NUM_PTR)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ptr_we),
        .sel   (ptr_sel),
        .wdata (next_byte),
        .ptr_q (ptr_q)
    );

    dmem_gpr #(.DW(DW), .DEPTH(BASE)) u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .idx   (eff_addr[GW-1:0]),
        .wdata (next_byte),
        .rdata (ram_rd)
    );

    // The pointer at 03H is entry 1, the pointer at 01H is entry 0
    assign ptr_sel = (eff_addr == PTR1_ADDR) ? 1'b1 : 1'b0;

    // Fetch the current byte of the resolved location
    always_comb begin
        unique case (region)
            RGN_PTR: cur_byte = (eff_addr == PTR1_ADDR) ? mp1 : mp0;
            RGN_SFR: cur_byte = per_rdata;
            RGN_GPR: cur_byte = ram_rd;
            default: cur_byte = '0;
        endcase
    end

    // Build the updated byte: a byte write first, then set, then clear
    always_comb begin
        bit_mask = '0;
        bit_mask[bit_idx] = 1'b1;
        if (wr_en)        next_byte = wdata;
        else if (bset_en) next_byte = cur_byte | bit_mask;
        else              next_byte = cur_byte & ~bit_mask;
    end

    assign bit_op = bset_en || bclr_en;
    assign commit = (wr_en || bit_op) && writable;

    // Route the commit to exactly one storage region
    assign ram_we = commit && (region == RGN_GPR);
    assign ptr_we = commit && (region == RGN_PTR);

    // Peripheral side port
    assign per_addr  = eff_addr;
    assign per_we    = commit && (region == RGN_SFR);
    assign per_re    = rd_en && (region == RGN_SFR);
    assign per_wdata = next_byte;

    // Read data is gated by the read strobe
    assign rdata = rd_en ? cur_byte : '0;
endmodule

// File: rtl/datamem_core_chk.sv
// Module: property checker for datamem_core, attached with bind.
module datamem_core_chk
    import dmem_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int BASE = GPR_BASE,
    parameter logic [BASE-1:0] SFR_MAP = DEF_SFR_MAP,
    parameter logic [BASE-1:0] RO_MAP  = DEF_RO_MAP
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [AW-1:0]         addr,
    input logic [DW-1:0]         wdata,
    input logic                  rd_en,
    input logic                  wr_en,
    input logic                  bset_en,
    input logic                  bclr_en,
    input logic [$clog2(DW)-1:0] bit_idx,
    input logic [DW-1:0]         rdata,
    input logic [AW-1:0]         per_addr,
    input logic                  per_we,
    input logic [DW-1:0]         per_wdata,
    input logic [DW-1:0]         mp0,
    input logic [DW-1:0]         mp1
);
    localparam int LW = $clog2(BASE);

    // R11
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);

    // R7
    sfr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_we |-> (int'(per_addr) < BASE) && SFR_MAP[per_addr[LW-1:0]]);

    // R8
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_we |-> !RO_MAP[per_addr[LW-1:0]]);

    // R12
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == PTR0_ADDR) |=> mp0 == $past(wdata));

    // R6
    self_ind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || bset_en || bclr_en) && addr == IND0_ADDR &&
         (mp0[AW-1:0] == IND0_ADDR || mp0[AW-1:0] == IND1_ADDR))
        |=> $stable(mp0) && $stable(mp1));

    // R9
    bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && bset_en && per_we) |-> per_wdata[bit_idx]);

    // R9
    bit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !bset_en && bclr_en && per_we) |-> !per_wdata[bit_idx]);

    // R10
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && per_we) |-> per_wdata == wdata);
endmodule

bind datamem_core datamem_core_chk #(
    .AW(AW), .DW(DW), .BASE(BASE), .SFR_MAP(SFR_MAP), .RO_MAP(RO_MAP)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wdata     (wdata),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .bset_en   (bset_en),
    .bclr_en   (bclr_en),
    .bit_idx   (bit_idx),
    .rdata     (rdata),
    .per_addr  (per_addr),
    .per_we    (per_we),
    .per_wdata (per_wdata),
    .mp0       (mp0),
    .mp1       (mp1)
);

// File: tb/datamem_core_tb_top.sv
// Bench: a behavioural reference model is compared with the design on every cycle.
`timescale 1ns/1ps
module datamem_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0, bset_en = 1'b0, bclr_en = 1'b0;
    logic [2:0] bit_idx = '0;
    logic [7:0] rdata;
    logic [6:0] per_addr;
    logic       per_re, per_we;
    logic [7:0] per_wdata;
    logic [7:0] per_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    datamem_core dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .wr_en(wr_en), .bset_en(bset_en), .bclr_en(bclr_en),
        .bit_idx(bit_idx), .rdata(rdata), .per_addr(per_addr),
        .per_re(per_re), .per_we(per_we), .per_wdata(per_wdata),
        .per_rdata(per_rdata)
    );

    // Peripheral register file of the environment
    logic [7:0] periph [64];
    assign per_rdata = per_addr[6] ? 8'h00 : periph[per_addr[5:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) periph[i] <= 8'h00;
            periph[8]  <= 8'h5A;
            periph[10] <= 8'hC3;
        end else if (per_we && !per_addr[6]) begin
            periph[per_addr[5:0]] <= per_wdata;
        end
    end

    // Reference model state
    int ref_ram [64];
    int ref_mp  [2];
    int ref_sfr [64];

    function automatic bit is_sfr(int a);
        return (a >= 4 && a <= 11) || a == 18 || a == 20 || a == 30 ||
               (a >= 32 && a <= 37);
    endfunction

    function automatic int resolve(int a);
        if (a == 0) return ref_mp[0] % 128;
        if (a == 2) return ref_mp[1] % 128;
        return a;
    endfunction

    function automatic int model_read(int e);
        if (e == 1) return ref_mp[0];
        if (e == 3) return ref_mp[1];
        if (e >= 64) return ref_ram[e - 64];
        if (is_sfr(e)) return ref_sfr[e];
        return 0;
    endfunction

    function automatic bit model_writable(int e);
        if (e == 0 || e == 2) return 1'b0;
        if (e == 1 || e == 3 || e >= 64) return 1'b1;
        return is_sfr(e) && e != 8 && e != 10;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive, compare outputs before the edge, advance the model
    task automatic step(input int a, input int wd, input bit rd, input bit wr,
                        input bit bs, input bit bc, input int bi, input string req);
        int e, cur, nxt, exp_rd;
        bit act, exp_pwe, exp_pre;
        @(negedge clk);
        addr = a[6:0]; wdata = wd[7:0]; rd_en = rd; wr_en = wr;
        bset_en = bs; bclr_en = bc; bit_idx = bi[2:0];
        #1;
        e   = resolve(a);
        cur = model_read(e);
        exp_rd = rd ? cur : 0;
        if (wr)      nxt = wd;
        else if (bs) nxt = cur | (1 << bi);
        else         nxt = cur & ~(1 << bi) & 255;
        act     = wr || bs || bc;
        exp_pwe = act && model_writable(e) && is_sfr(e);
        exp_pre = rd && is_sfr(e);
        check(rdata == exp_rd[7:0], req, "rdata", int'(rdata), exp_rd);
        check(per_we == exp_pwe, req, "per_we", int'(per_we), int'(exp_pwe));
        check(per_re == exp_pre, req, "per_re", int'(per_re), int'(exp_pre));
        if (exp_pwe || exp_pre)
            check(per_addr == e[6:0], req, "per_addr", int'(per_addr), e);
        if (exp_pwe)
            check(per_wdata == nxt[7:0], req, "per_wdata", int'(per_wdata), nxt);
        if (act && model_writable(e)) begin
            if (e == 1)       ref_mp[0] = nxt;
            else if (e == 3)  ref_mp[1] = nxt;
            else if (e >= 64) ref_ram[e - 64] = nxt;
            else              ref_sfr[e] = nxt;
        end
    endtask

    task automatic rd(input int a, input string req);
        step(a, 0, 1, 0, 0, 0, 0, req);
    endtask
    task automatic wr(input int a, input int d, input string req);
        step(a, d, 0, 1, 0, 0, 0, req);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin ref_ram[i] = 0; ref_sfr[i] = 0; end
        ref_mp[0] = 0; ref_mp[1] = 0;
        ref_sfr[8] = 8'h5A; ref_sfr[10] = 8'hC3;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(1, "R1"); rd(3, "R1"); rd(8'h40, "R1"); rd(8'h7F, "R1");
        // R2 direct RAM, read during write sees old byte
        wr(8'h40, 8'hA5, "R2"); rd(8'h40, "R2");
        wr(8'h7F, 8'h3C, "R2"); rd(8'h7F, "R2");
        step(8'h40, 8'h11, 1, 1, 0, 0, 0, "R2"); rd(8'h40, "R2");
        // R3 reserved
        wr(8'h0C, 8'hFF, "R3"); rd(8'h0C, "R3");
        step(8'h26, 0, 1, 0, 1, 0, 3, "R3"); rd(8'h3F, "R3");
        // R12 and R4 pointer 0
        wr(1, 8'h45, "R12"); rd(1, "R12");
        wr(0, 8'h77, "R4"); rd(8'h45, "R4"); rd(0, "R4");
        wr(1, 8'hC5, "R12"); rd(0, "R12"); rd(1, "R12");
        // R5 pointer 1, including writing pointer 0 through it
        wr(3, 8'h50, "R5"); wr(2, 8'h9E, "R5"); rd(8'h50, "R5");
        wr(3, 8'h01, "R5"); wr(2, 8'h46, "R5"); rd(1, "R5"); rd(0, "R5");
        // R6 pointer aimed at an indirect port
        wr(1, 8'h00, "R6"); wr(0, 8'hFF, "R6"); rd(0, "R6");
        step(0, 0, 1, 0, 1, 0, 5, "R6"); rd(1, "R6");
        wr(3, 8'h82, "R6"); wr(2, 8'hEE, "R6"); rd(2, "R6"); rd(3, "R6");
        rd(8'h40, "R6"); rd(8'h45, "R6");
        // R7 peripheral registers
        wr(5, 8'h12, "R7"); rd(5, "R7"); wr(8'h25, 8'h81, "R7"); rd(8'h25, "R7");
        wr(8'h1E, 8'h44, "R7"); rd(8'h1E, "R7"); rd(8'h12, "R7");
        wr(1, 8'h14, "R7"); wr(0, 8'h6B, "R7"); rd(8'h14, "R7");
        // R8 read-only registers
        wr(8, 8'hFF, "R8"); rd(8, "R8");
        step(10, 0, 1, 0, 0, 1, 7, "R8"); rd(10, "R8");
        // R9 single-bit updates
        for (int b = 0; b < 8; b++) step(8'h41, 0, 1, 0, 1, 0, b, "R9");
        rd(8'h41, "R9");
        for (int b = 0; b < 8; b += 2) step(8'h41, 0, 1, 0, 0, 1, b, "R9");
        rd(8'h41, "R9");
        step(5, 0, 1, 0, 1, 0, 6, "R9"); step(5, 0, 1, 0, 0, 1, 1, "R9"); rd(5, "R9");
        wr(3, 8'h60, "R9"); step(2, 0, 1, 0, 1, 0, 4, "R9"); rd(8'h60, "R9");
        step(3, 0, 1, 0, 0, 1, 5, "R9"); rd(3, "R9");
        // R10 coinciding strobes
        step(8'h42, 8'h0F, 1, 1, 1, 0, 7, "R10"); rd(8'h42, "R10");
        step(8'h42, 0, 1, 0, 1, 1, 6, "R10"); rd(8'h42, "R10");
        step(4, 8'h00, 1, 1, 1, 1, 2, "R10"); step(4, 0, 1, 0, 1, 1, 3, "R10"); rd(4, "R10");
        // R11 read strobe low
        step(8'h40, 0, 0, 0, 0, 0, 0, "R11"); step(1, 0, 0, 0, 0, 0, 0, "R11");
        step(6, 0, 0, 0, 0, 0, 0, "R11");
        // Mixed random traffic, all requirements cross-checked by the model
        for (int k = 0; k < 600; k++) begin
            int a, sel;
            sel = $urandom_range(0, 9);
            a = (sel < 2) ? sel * 2 : (sel < 4) ? (sel - 2) * 2 + 1
                : (sel < 7) ? $urandom_range(64, 127) : $urandom_range(0, 63);
            step(a, $urandom_range(0, 255), $urandom_range(0, 1), $urandom_range(0, 1),
                 $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 7), "R10");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule